// File: doc/BRIEF.md
# Ethernet Transmit Frame Engine

This block sends one Ethernet frame at a time out of a word-organised transmit buffer. Software fills the buffer, then writes a single command word holding the frame length in octets, two option flags and a start flag. The engine reads the buffer one octet at a time and reformats the header according to the option flags. It pads short frames, appends the frame check sequence, and presents the octets on a byte-wide valid/ready stream that feeds a serializer toward the PHY.

The start flag doubles as the busy indicator and as the abort control. It reads back as set for as long as the frame is on its way, and writing a word with it clear aborts the frame. A reset flag keeps the engine dormant after power-up until software clears it. An idle interrupt is high while the engine is released from reset and has nothing to send.

The buffer is read combinationally: the engine drives a word address and expects the word on `bufData` in the same cycle.

Top module: `eth_tx_engine`

## Requirements
- R1: After `rst_n` deassertion the command readback shows the reset flag (bit 17) set and the start flag (bit 14) clear, `txValid` is low and `idleIrq` is low.
- R2: A command write with bit 17 clear releases the reset state, and the start flag in that same write is ignored. A command write with bit 17 set returns the engine to the reset state and aborts any frame in progress.
- R3: A write made while out of reset and idle, with bit 14 set and a nonzero length in bits 10:0, starts a frame. Bit 14 then reads 1 and `txValid` stays high until the handshake of the last octet, after which both are 0 in the next cycle. A start with length zero is ignored.
- R4: Buffer octet n is taken from word n/4, lane n mod 4, with lane 0 in bits 31:24.
- R5: With bit 15 clear (address insertion on), the wire carries buffer octets 0 to 5, then the six `stationMac` octets starting with bits 47:40, then buffer octets 6 onward.
- R6: With bit 15 set, the wire carries every buffer octet in order except buffer octets 14 and 15, the second copy of the EtherType.
- R7: With bit 16 clear (checksum on), zero octets are appended until the frame holds 60 octets. Then the CRC-32 over all frame octets follows, least significant octet first. The CRC uses the reflected polynomial 0xEDB88320, an all-ones start value and a complemented result.
- R8: With bit 16 set, no padding or CRC is added, and the frame ends with its last buffer octet.
- R9: While `txValid` is high and `txReady` is low, `txValid` and `txData` hold their values.
- R10: A command write with bit 14 clear during a frame aborts it: `txValid` and bit 14 are 0 in the next cycle. A write with bit 14 set during a frame is ignored, and the frame continues unchanged.
- R11: `idleIrq` is high exactly when bit 14 reads 0 and bit 17 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmdWrEn | input | 1 | Command register write strobe |
| cmdWrData | input | 32 | Command word: length 10:0, start 14, raw header 15, no CRC 16, reset 17 |
| cmdRdData | output | 32 | Command register readback, same layout |
| bufAddr | output | LEN_W-2 | Transmit buffer word address |
| bufData | input | 32 | Transmit buffer word at `bufAddr`, same cycle |
| stationMac | input | 48 | Own station address, first wire octet in bits 47:40 |
| txData | output | 8 | Outgoing octet |
| txValid | output | 1 | Octet on `txData` is valid |
| txReady | input | 1 | Downstream accepts the octet this cycle |
| idleIrq | output | 1 | Transmitter idle and released from reset |

## Verification
The bench targets the header boundaries. Lengths that end exactly at the address insertion point, or inside the duplicated EtherType, would expose an engine that inserts the address twice, skips the wrong pair, or runs past the frame end. It sends frames that reach exactly 60 octets and frames just short of that, where an off-by-one pad counter would emit one pad octet too many or too few and corrupt the CRC. It aborts a frame and resets the engine in mid-frame, and it writes a start during reset and during a busy frame. An engine that let any of these writes through would restart the frame or leave `txValid` raised. Random backpressure exposes a stream that advances or changes data while stalled.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;
  localparam int GO_BIT    = 14;
  localparam int RAWHDR_BIT = 15;
  localparam int NOCRC_BIT = 16;
  localparam int RST_BIT   = 17;

  typedef enum logic [1:0] {SRC_BUF, SRC_MAC, SRC_PAD, SRC_CRC} srcSel_e;

  typedef struct packed {
    srcSel_e    sel;
    logic [2:0] macIdx;
    logic [1:0] lane;
    logic [1:0] crcIdx;
    logic       crcClear;
    logic       crcStep;
  } txStrobes_t;

  function automatic logic [31:0] crcNext(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/eth_tx_ctrl.sv
module eth_tx_ctrl
  import eth_tx_pkg::*;
#(
  parameter int LEN_W     = 11,
  parameter int MIN_FRAME = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdWrEn,
  input  logic [31:0]       cmdWrData,
  output logic [31:0]       cmdRdData,
  input  logic              txReady,
  output logic              txValid,
  output logic              idleIrq,
  output logic [LEN_W-3:0]  bufAddr,
  output txStrobes_t        strb
);
  localparam int CNT_W   = LEN_W + 1;
  localparam int MAC_AT  = 5;   // last destination octet before insertion
  localparam int SKIP_AT = 13;  // last octet of first EtherType copy
  localparam int SKIP_TO = 16;  // first octet after duplicate copy

  logic inReset, busy, rawHdr, noCrc;
  logic [LEN_W-1:0] lenReg, bufIdx, nextIdx, wrLen;
  srcSel_e phase;
  logic [2:0] macIdx;
  logic [1:0] crcIdx;
  logic [CNT_W-1:0] wireCnt;
  logic hs, toMac, bodyEnd, lastMac, padNeeded, enterTail, startOk;
  logic unusedWrBits;

  assign wrLen = cmdWrData[LEN_W-1:0];
  assign unusedWrBits = ^{cmdWrData[31:RST_BIT+1], cmdWrData[GO_BIT-1:LEN_W]};

  always_comb begin
    hs        = busy && txReady;
    nextIdx   = (rawHdr && bufIdx == LEN_W'(SKIP_AT)) ? LEN_W'(SKIP_TO) : bufIdx + 1'b1;
    toMac     = !rawHdr && bufIdx == LEN_W'(MAC_AT);
    bodyEnd   = nextIdx >= lenReg;
    lastMac   = macIdx == 3'd5;
    padNeeded = (wireCnt + 1'b1) < CNT_W'(MIN_FRAME);
    enterTail = hs && ((phase == SRC_BUF && !toMac && bodyEnd) ||
                       (phase == SRC_MAC && lastMac && bufIdx >= lenReg));
    startOk   = cmdWrEn && !cmdWrData[RST_BIT] && !inReset && !busy &&
                cmdWrData[GO_BIT] && wrLen != '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inReset <= 1'b1;
      busy    <= 1'b0;
      rawHdr  <= 1'b0;
      noCrc   <= 1'b0;
      lenReg  <= '0;
      bufIdx  <= '0;
      phase   <= SRC_BUF;
      macIdx  <= '0;
      crcIdx  <= '0;
      wireCnt <= '0;
    end else begin
      if (hs) begin
        if (phase != SRC_CRC) wireCnt <= wireCnt + 1'b1;
        unique case (phase)
          SRC_BUF: begin
            bufIdx <= nextIdx;
            if (toMac) begin
              phase  <= SRC_MAC;
              macIdx <= '0;
            end
          end
          SRC_MAC: begin
            macIdx <= macIdx + 1'b1;
            if (lastMac) phase <= SRC_BUF;
          end
          SRC_PAD: begin
            if (!padNeeded) begin
              phase  <= SRC_CRC;
              crcIdx <= '0;
            end
          end
          SRC_CRC: begin
            crcIdx <= crcIdx + 1'b1;
            if (crcIdx == 2'd3) busy <= 1'b0;
          end
        endcase
      end
      if (enterTail) begin
        if (noCrc) busy <= 1'b0;
        else if (padNeeded) phase <= SRC_PAD;
        else begin
          phase  <= SRC_CRC;
          crcIdx <= '0;
        end
      end
      if (cmdWrEn) begin
        if (cmdWrData[RST_BIT]) begin
          inReset <= 1'b1;
          busy    <= 1'b0;
        end else if (inReset) begin
          inReset <= 1'b0;
        end else if (busy) begin
          if (!cmdWrData[GO_BIT]) busy <= 1'b0;
        end else if (startOk) begin
          busy    <= 1'b1;
          lenReg  <= wrLen;
          rawHdr  <= cmdWrData[RAWHDR_BIT];
          noCrc   <= cmdWrData[NOCRC_BIT];
          bufIdx  <= '0;
          phase   <= SRC_BUF;
          macIdx  <= '0;
          crcIdx  <= '0;
          wireCnt <= '0;
        end
      end
    end
  end

  always_comb begin
    cmdRdData             = '0;
    cmdRdData[LEN_W-1:0]  = lenReg;
    cmdRdData[GO_BIT]     = busy;
    cmdRdData[RAWHDR_BIT] = rawHdr;
    cmdRdData[NOCRC_BIT]  = noCrc;
    cmdRdData[RST_BIT]    = inReset;
  end

  assign txValid = busy;
  assign idleIrq = !busy && !inReset;
  assign bufAddr = bufIdx[LEN_W-1:2];

  always_comb begin
    strb.sel      = phase;
    strb.macIdx   = macIdx;
    strb.lane     = bufIdx[1:0];
    strb.crcIdx   = crcIdx;
    strb.crcClear = startOk;
    strb.crcStep  = hs && phase != SRC_CRC;
  end
endmodule

// File: rtl/eth_tx_dp.sv
module eth_tx_dp
  import eth_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  txStrobes_t  strb,
  input  logic [31:0] bufData,
  input  logic [47:0] stationMac,
  output logic [7:0]  txData
);
  logic [31:0] crcReg;
  logic [4:0]  laneShift;
  logic [5:0]  macShift;
  logic [4:0]  crcShift;

  always_comb begin
    laneShift = {~strb.lane, 3'b000};
    macShift  = {3'd5 - strb.macIdx, 3'b000};
    crcShift  = {strb.crcIdx, 3'b000};
    unique case (strb.sel)
      SRC_BUF: txData = 8'(bufData >> laneShift);
      SRC_MAC: txData = 8'(stationMac >> macShift);
      SRC_PAD: txData = 8'h00;
      SRC_CRC: txData = 8'(~crcReg >> crcShift);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crcReg <= '1;
    else if (strb.crcClear) crcReg <= '1;
    else if (strb.crcStep) crcReg <= crcNext(crcReg, txData);
  end
endmodule

// File: rtl/eth_tx_engine.sv
module eth_tx_engine
  import eth_tx_pkg::*;
#(
  parameter int LEN_W     = 11,
  parameter int MIN_FRAME = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmdWrEn,
  input  logic [31:0]      cmdWrData,
  output logic [31:0]      cmdRdData,
  output logic [LEN_W-3:0] bufAddr,
  input  logic [31:0]      bufData,
  input  logic [47:0]      stationMac,
  output logic [7:0]       txData,
  output logic             txValid,
  input  logic             txReady,
  output logic             idleIrq
);
  txStrobes_t strb;

  eth_tx_ctrl #(.LEN_W(LEN_W), .MIN_FRAME(MIN_FRAME)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .cmdRdData(cmdRdData), .txReady(txReady), .txValid(txValid),
    .idleIrq(idleIrq), .bufAddr(bufAddr), .strb(strb)
  );

  eth_tx_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .bufData(bufData),
    .stationMac(stationMac), .txData(txData)
  );
endmodule

// File: rtl/eth_tx_engine_chk.sv
module eth_tx_engine_chk
  import eth_tx_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        cmdWrEn,
  input logic [31:0] cmdWrData,
  input logic [31:0] cmdRdData,
  input logic [7:0]  txData,
  input logic        txValid,
  input logic        txReady,
  input logic        idleIrq
);
  assert_busy_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    txValid |-> cmdRdData[GO_BIT]);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (txValid && !txReady && !cmdWrEn) |=> (txValid && $stable(txData)));

  assert_quiet_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmdRdData[RST_BIT] |-> !txValid);

  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (txValid && cmdWrEn && !cmdWrData[GO_BIT]) |=> !txValid);

  assert_irq_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmdRdData[GO_BIT] && !cmdRdData[RST_BIT]) |-> idleIrq);

  assert_irq_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    idleIrq |-> (!cmdRdData[GO_BIT] && !cmdRdData[RST_BIT]));
endmodule

bind eth_tx_engine eth_tx_engine_chk u_chk (.*);

// File: tb/eth_tx_engine_tb.sv
`timescale 1ns/1ps
module eth_tx_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmdWrEn = 1'b0;
  logic [31:0] cmdWrData = '0;
  logic [31:0] cmdRdData;
  logic [8:0] bufAddr;
  logic [31:0] bufData;
  logic [47:0] stationMac = 48'h021A3C4D5E6F;
  logic [7:0] txData;
  logic txValid;
  logic txReady = 1'b0;
  logic idleIrq;
  logic [31:0] mem [512];

  int checks = 0;
  int errors = 0;
  string curReq = "R1";
  logic [7:0] q[$];
  bit expBusy = 0;
  bit expRst = 1;

  always #4 clk = ~clk;
  assign bufData = mem[bufAddr];

  eth_tx_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .cmdRdData(cmdRdData), .bufAddr(bufAddr), .bufData(bufData),
    .stationMac(stationMac), .txData(txData), .txValid(txValid),
    .txReady(txReady), .idleIrq(idleIrq)
  );

  task automatic check(bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", curReq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int len, bit raw, bit noCrc, bit go, bit rst);
    logic [31:0] w = '0;
    w[10:0] = 11'(len);
    w[14] = go; w[15] = raw; w[16] = noCrc; w[17] = rst;
    return w;
  endfunction

  function automatic logic [7:0] bufByte(int i);
    return 8'(mem[i / 4] >> (24 - 8 * (i % 4)));
  endfunction

  task automatic fillBuf(int len, int seed);
    for (int i = 0; i < len; i++) begin
      logic [7:0] b = 8'(i * 29 + seed);
      mem[i / 4][31 - 8 * (i % 4) -: 8] = b;
    end
  endtask

  task automatic buildFrame(int len, bit raw, bit noCrc);
    logic [31:0] c;
    q.delete();
    for (int i = 0; i < len; i++) begin
      if (!(raw && (i == 14 || i == 15))) q.push_back(bufByte(i));
      if (!raw && i == 5)
        for (int m = 5; m >= 0; m--) q.push_back(8'(stationMac >> (8 * m)));
    end
    if (!noCrc) begin
      while (q.size() < 60) q.push_back(8'h00);
      c = 32'hFFFFFFFF;
      foreach (q[k]) begin
        for (int b = 0; b < 8; b++) begin
          bit fb = c[0] ^ q[k][b];
          c = c >> 1;
          if (fb) c = c ^ 32'hEDB88320;
        end
      end
      c = ~c;
      for (int b = 0; b < 4; b++) q.push_back(8'(c >> (8 * b)));
    end
  endtask

  task automatic compare();
    check(txValid === expBusy, "txValid", txValid, expBusy);
    if (expBusy && q.size() > 0) check(txData === q[0], "txData", txData, q[0]);
    check(cmdRdData[14] === expBusy, "start flag", cmdRdData[14], expBusy);
    check(cmdRdData[17] === expRst, "reset flag", cmdRdData[17], expRst);
    check(idleIrq === (!expBusy && !expRst), "idleIrq R11", idleIrq, !expBusy && !expRst);
  endtask

  task automatic tick(bit rdy, bit wr, logic [31:0] wd);
    bit wasBusy = expBusy;
    txReady = rdy; cmdWrEn = wr; cmdWrData = wd;
    if (expBusy && rdy) begin
      void'(q.pop_front());
      if (q.size() == 0) expBusy = 0;
    end
    if (wr) begin
      if (wd[17]) begin expRst = 1; expBusy = 0; q.delete(); end
      else if (expRst) expRst = 0;
      else if (wasBusy) begin
        if (!wd[14]) begin expBusy = 0; q.delete(); end
      end else if (wd[14] && wd[10:0] != 0) begin
        buildFrame(int'(wd[10:0]), wd[15], wd[16]);
        expBusy = 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    cmdWrEn = 1'b0;
    compare();
  endtask

  task automatic runFrame(int len, bit raw, bit noCrc, int pat, int seed);
    int guard = 0;
    fillBuf(len, seed);
    tick(1, 1, mk(len, raw, noCrc, 1, 0));
    check(expBusy == 1, "frame accepted", expBusy, 1);
    while (expBusy && guard < 5000) begin
      bit r = (pat == 0) ? 1'b1 : (pat == 1) ? ($urandom % 3 != 0) : 1'(guard % 2);
      tick(r, 0, '0);
      guard++;
    end
    tick(1, 0, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    foreach (mem[i]) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    curReq = "R1";
    compare();
    tick(1, 0, '0);

    curReq = "R2";  // start flag ignored while releasing reset
    tick(1, 1, mk(20, 0, 0, 1, 0));
    tick(1, 0, '0);

    curReq = "R3";  // zero length start ignored
    tick(1, 1, mk(0, 0, 0, 1, 0));
    tick(1, 0, '0);

    curReq = "R3 R4 R5 R7";  // short padded frame with address insertion
    runFrame(20, 0, 0, 0, 3);
    curReq = "R4 R6 R7 R9";  // raw header, long frame, random stall
    runFrame(70, 1, 0, 1, 11);
    curReq = "R6 R8 R9";  // raw header, no checksum, alternating stall
    runFrame(64, 1, 1, 2, 5);
    curReq = "R5 R8";  // ends exactly at insertion point
    runFrame(6, 0, 1, 0, 7);
    curReq = "R6 R8";  // ends inside duplicate EtherType
    runFrame(15, 1, 1, 0, 9);
    curReq = "R5 R7";  // exactly 60 octets with insertion, no pad
    runFrame(54, 0, 0, 1, 13);
    curReq = "R6 R7";  // exactly 60 wire octets in raw mode
    runFrame(62, 1, 0, 0, 17);
    curReq = "R7";  // one short of 60, single pad octet
    runFrame(53, 0, 0, 0, 19);

    curReq = "R10";  // start write while busy ignored, then abort
    fillBuf(40, 23);
    tick(1, 1, mk(40, 0, 1, 1, 0));
    repeat (5) tick(1, 0, '0);
    tick(1, 1, mk(12, 1, 0, 1, 0));
    repeat (4) tick(0, 0, '0);
    repeat (4) tick(1, 0, '0);
    tick(1, 1, 32'h0);
    check(txValid === 1'b0, "abort R10", txValid, 0);
    repeat (3) tick(1, 0, '0);

    curReq = "R2";  // reset in mid-frame, then release ignores start
    tick(1, 1, mk(40, 0, 0, 1, 0));
    repeat (6) tick(1, 0, '0);
    tick(1, 1, mk(40, 0, 0, 0, 1));
    check(txValid === 1'b0, "reset abort R2", txValid, 0);
    repeat (3) tick(1, 0, '0);
    tick(1, 1, mk(30, 0, 0, 1, 0));
    repeat (2) tick(1, 0, '0);
    curReq = "R2 R3 R5 R7";
    runFrame(30, 0, 0, 1, 29);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule